// File: doc/BRIEF.md
# Segment Boundary Background Calibrator

This block removes the jump in switching period that appears where the resolution controller of a digital off-time modulator moves from one unit delay to the next coarser one. For every boundary between neighbouring delay segments it runs two modulator copies side by side. The reference copy holds the last code of the lower segment at the lower segment's delay. The trial copy holds a candidate code at the upper segment's delay. A single phase flip-flop decides which off-time ends first. The block writes the code at which the upper segment first produces an off-time no longer than the reference, plus one unit of margin, into a boundary table. Normal operation then uses that table to remap codes.

The two modulator copies sit outside the block and are driven through its ports. Each trial starts with a one-cycle launch pulse and ends when either copy reports the end of its off-time. The boundaries are calibrated one after another, lowest first. A done flag marks a full table, and an error flag marks a boundary whose search ran down to the floor of the lower segment without the comparison ever flipping.

Top module: `seg_boundary_cal`

## Requirements
- R1: After reset `mod_start`, `cal_done` and `cal_err` are low and every entry of `cal_table` is zero.
- R2: Each trial begins with `mod_start` high for exactly one cycle. During the trial `ref_code` equals the boundary start code minus one, `ref_dsel` equals the boundary index k, and `trial_dsel` equals k+1.
- R3: The first trial of boundary k uses the trial code equal to that boundary's start code. The start codes are the parameter `BND`, with boundary k in bits [k*CW +: CW].
- R4: When the reference end arrives strictly before the trial end (ref_end=1, trial_end=0 in the deciding cycle), the next trial of the same boundary uses the trial code lowered by exactly one.
- R5: When the trial end arrives first, or both ends arrive in the same cycle, the search stops and table entry k becomes that trial code plus one.
- R6: When the reference wins while the trial code equals the floor, the search stops, `cal_err` rises and stays high, and entry k becomes the start code. The floor is `MIN_CODE` for boundary 0 and the start code of boundary k-1 otherwise.
- R7: Boundaries are calibrated in ascending order of k. `cal_done` rises after the last entry is stored and stays high until the next accepted `cal_start`.
- R8: `cal_start` is ignored while a calibration is running. It does not change the trial sequence or the stored results.
- R9: The trial code and the reference code stay constant from the launch pulse until the end of their trial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | Begin a full calibration pass (accepted only when idle) |
| ref_end | input | 1 | End-of-off-time pulse from the reference modulator copy |
| trial_end | input | 1 | End-of-off-time pulse from the trial modulator copy |
| mod_start | output | 1 | One-cycle launch of both modulator copies |
| ref_code | output | CW | Code for the reference copy |
| ref_dsel | output | SW | Unit-delay select for the reference copy |
| trial_code | output | CW | Code for the trial copy |
| trial_dsel | output | SW | Unit-delay select for the trial copy |
| cal_table | output | (NSEG-1)*CW | Calibrated boundary codes, entry k in bits [k*CW +: CW] |
| cal_done | output | 1 | All boundaries stored |
| cal_err | output | 1 | At least one boundary hit its floor |

## Verification
The two end reports are the pair that can land in the same cycle. A tie between them must count as "trial not too long", so the search stops and does not step down once more. The bench provokes this with equal unit delays on both sides of a boundary, which makes the two tick-level periods identical at one code, and with random response latencies on other runs. The stored entry is judged against a bench function that applies the stop rule with "less than or equal". A second collision, the floor being reached in the same decision that the reference still wins, is forced by a very large upper delay and judged through `cal_err` and the start-code entry.

// File: rtl/seg_boundary_cal.sv
module seg_boundary_cal #(
  parameter int CW = 10,
  parameter int NSEG = 4,
  parameter logic [(NSEG-1)*CW-1:0] BND = {10'd512, 10'd256, 10'd128},
  parameter int MIN_CODE = 1,
  localparam int NB = NSEG - 1,
  localparam int SW = $clog2(NSEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start,
  input  logic              ref_end,
  input  logic              trial_end,
  output logic              mod_start,
  output logic [CW-1:0]     ref_code,
  output logic [SW-1:0]     ref_dsel,
  output logic [CW-1:0]     trial_code,
  output logic [SW-1:0]     trial_dsel,
  output logic [NB*CW-1:0]  cal_table,
  output logic              cal_done,
  output logic              cal_err
);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CMP, S_DEC, S_MARGIN, S_STORE} state_t;

  state_t        st;
  logic [SW-1:0] k;
  logic [CW-1:0] trial;
  logic [CW-1:0] tbl [NB];
  logic [CW-1:0] bnd_a [NB];
  logic [CW-1:0] flr_a [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bnd
    assign bnd_a[g] = BND[g*CW +: CW];
    if (g == 0) begin : g_first
      assign flr_a[g] = CW'(MIN_CODE);
    end else begin : g_rest
      assign flr_a[g] = BND[(g-1)*CW +: CW];
    end
    assign cal_table[g*CW +: CW] = tbl[g];
  end

  wire ref_wins = ref_end & ~trial_end;
  wire decided  = ref_end | trial_end;
  wire last_k   = (k == SW'(NB-1));

  assign mod_start  = (st == S_LOAD);
  assign ref_code   = bnd_a[k] - CW'(1);
  assign ref_dsel   = k;
  assign trial_code = trial;
  assign trial_dsel = k + SW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      k        <= '0;
      trial    <= '0;
      cal_done <= 1'b0;
      cal_err  <= 1'b0;
      for (int i = 0; i < NB; i++) tbl[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (cal_start) begin
          k        <= '0;
          trial    <= bnd_a[0];
          cal_done <= 1'b0;
          cal_err  <= 1'b0;
          st       <= S_LOAD;
        end
        S_LOAD: st <= S_CMP;
        S_CMP: if (decided) begin
          if (ref_wins) begin
            if (trial == flr_a[k]) begin
              cal_err <= 1'b1;
              trial   <= bnd_a[k];
              st      <= S_STORE;
            end else begin
              st <= S_DEC;
            end
          end else begin
            st <= S_MARGIN;
          end
        end
        S_DEC: begin
          trial <= trial - CW'(1);
          st    <= S_LOAD;
        end
        S_MARGIN: begin
          trial <= trial + CW'(1);
          st    <= S_STORE;
        end
        S_STORE: begin
          tbl[k] <= trial;
          if (last_k) begin
            cal_done <= 1'b1;
            st       <= S_IDLE;
          end else begin
            k     <= k + SW'(1);
            trial <= bnd_a[k + SW'(1)];
            st    <= S_LOAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_launch_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mod_start |=> !mod_start);

  p_sel_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mod_start |-> (trial_dsel == ref_dsel + SW'(1)) && (ref_code == bnd_a[ref_dsel] - CW'(1)));

  p_codes_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMP) |-> ($stable(trial_code) && $stable(ref_code)));

  p_trial_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mod_start |-> (trial_code >= flr_a[k]) && (trial_code <= bnd_a[k]));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_err && !(st == S_IDLE && cal_start)) |=> cal_err);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (st == S_IDLE) && !mod_start);

endmodule

// File: tb/test_seg_boundary_cal.sv
module test_seg_boundary_cal;
  localparam int CW = 10;
  localparam int NSEG = 4;
  localparam int NB = NSEG - 1;
  localparam int SW = 2;
  localparam int B [NB] = '{128, 256, 512};

  logic clk = 0, rst_n = 0, cal_start = 0, ref_end = 0, trial_end = 0;
  logic mod_start, cal_done, cal_err;
  logic [CW-1:0] ref_code, trial_code;
  logic [SW-1:0] ref_dsel, trial_dsel;
  logic [NB*CW-1:0] cal_table;

  int checks = 0, fails = 0;
  int u [NSEG];
  int cnt [NB];
  int last_trial [NB];
  int last_dsel;

  always #10 clk = ~clk;

  seg_boundary_cal i_seg_boundary_cal (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .ref_end(ref_end),
    .trial_end(trial_end), .mod_start(mod_start), .ref_code(ref_code),
    .ref_dsel(ref_dsel), .trial_code(trial_code), .trial_dsel(trial_dsel),
    .cal_table(cal_table), .cal_done(cal_done), .cal_err(cal_err));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void calc(input int k, output int code, output bit err, output int trials);
    int c = B[k];
    int flr = (k == 0) ? 1 : B[k-1];
    int p = (B[k] - 1) * u[k];
    err = 0; trials = 0;
    forever begin
      trials++;
      if (p < c * u[k+1]) begin
        if (c == flr) begin err = 1; code = B[k]; return; end
        c--;
      end else begin
        code = c + 1; return;
      end
    end
  endfunction

  // tick-level model of the two modulator copies
  initial begin
    forever begin
      @(negedge clk);
      if (mod_start) begin
        automatic int kk = int'(ref_dsel);
        automatic int pa = int'(ref_code) * u[ref_dsel];
        automatic int pb = int'(trial_code) * u[trial_dsel];
        automatic int lat = 1 + ($urandom % 3);
        check(trial_dsel == ref_dsel + 1 && ref_code == B[kk] - 1, "R2", int'(ref_code), B[kk] - 1);
        check(kk >= last_dsel, "R7", kk, last_dsel);
        if (cnt[kk] == 0) check(trial_code == B[kk], "R3", int'(trial_code), B[kk]);
        else check(int'(trial_code) == last_trial[kk] - 1, "R4", int'(trial_code), last_trial[kk] - 1);
        cnt[kk]++;
        last_trial[kk] = int'(trial_code);
        last_dsel = kk;
        @(negedge clk);
        check(!mod_start, "R2", int'(mod_start), 0);
        repeat (lat - 1) @(negedge clk);
        check(int'(trial_code) == last_trial[kk], "R9", int'(trial_code), last_trial[kk]);
        ref_end = (pa < pb) || (pa == pb);
        trial_end = (pb <= pa);
        @(negedge clk);
        ref_end = 0; trial_end = 0;
      end
    end
  end

  task automatic run(input int a, input int b, input int c, input int d, input bit poke);
    int code, tr; bit e, any_err;
    u[0] = a; u[1] = b; u[2] = c; u[3] = d;
    for (int i = 0; i < NB; i++) cnt[i] = 0;
    last_dsel = 0;
    @(negedge clk); cal_start = 1;
    @(negedge clk); cal_start = 0;
    if (poke) begin
      repeat (15) @(negedge clk);
      cal_start = 1;
      @(negedge clk); cal_start = 0;
    end
    check(!cal_done, "R7", int'(cal_done), 0);
    while (!cal_done) @(negedge clk);
    any_err = 0;
    for (int k = 0; k < NB; k++) begin
      calc(k, code, e, tr);
      any_err |= e;
      check(int'(cal_table[k*CW +: CW]) == code, e ? "R6" : "R5", int'(cal_table[k*CW +: CW]), code);
      check(cnt[k] == tr, poke ? "R8" : "R4", cnt[k], tr);
    end
    check(cal_err == any_err, "R6", int'(cal_err), int'(any_err));
    repeat (5) @(negedge clk);
    check(cal_done && !mod_start, "R7", int'(cal_done), 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!mod_start && !cal_done && !cal_err, "R1", int'(cal_done), 0);
    check(cal_table == '0, "R1", int'(cal_table[CW-1:0]), 0);
    rst_n = 1;
    run(1, 2, 4, 8, 0);     // plain halving
    run(2, 2, 3, 3, 0);     // equal periods: both ends in one cycle
    run(1, 200, 1, 1, 0);   // boundary 0 runs down to its floor
    run(3, 5, 7, 9, 1);     // start request while busy
    for (int n = 0; n < 5; n++)
      run(1 + $urandom % 9, 1 + $urandom % 9, 1 + $urandom % 9, 1 + $urandom % 9, n[0]);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule